// File: doc/BRIEF.md
# Saturate and Packed Dot-Product Execution Unit

This unit executes three custom R-type integer operations meant for quantised neural-network kernels. It sits beside the main ALU of a 32-bit core. Each cycle it may receive one instruction word with a valid strobe, together with the values of the two source registers and the current value of the destination register. The destination value is needed because two of the operations accumulate into it. One clock edge later the unit presents a write enable, the destination index and the result, or it flags the instruction as illegal.

The three operations are as follows. The first clamps a value to a signed width. The value is first shifted arithmetically right by a count taken from a register, and the width comes from the top seven instruction bits. The second is a four-lane signed byte dot product added onto the destination value. The third is a signed 32-bit multiply whose low word is added to the destination value. The register file read ports and any forwarding belong to the surrounding pipeline.

Top module: `nnx_alu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `wr_en` and `illegal` are 0.
- R2: The unit acts only on `instr[6:0]` = 7'b0101011. The destination index is `instr[11:7]`, the operation select is `instr[14:12]` and the width/qualifier field is `instr[31:25]`. Any other opcode gives `wr_en` = 0 and `illegal` = 0.
- R3: Saturate (select 3'b000) first shifts `src_a` arithmetically right by the value of `src_b`, so the sign bit is replicated into the vacated positions.
- R4: Saturate takes N from `instr[31:25]` and clamps the shifted value to the range -2^(N-1) .. 2^(N-1)-1.
- R5: Saturate writes only when N is between 1 and 32 inclusive and the full 32-bit `src_b` is below 32. Otherwise `wr_en` is 0 and `illegal` is 0.
- R6: The dot product (select 3'b001, qualifier 0) multiplies the signed bytes of `src_a` and `src_b` at bits 7:0, 15:8, 23:16 and 31:24 lane by lane, then sums the four products.
- R7: The dot-product sum is added to `src_d` as a signed value. The low 32 bits are written, so the addition wraps.
- R8: Multiply-accumulate (select 3'b010, qualifier 0) writes the low 32 bits of signed `src_a` times `src_b`, plus `src_d`.
- R9: No operation asserts `wr_en` when the destination index is 0.
- R10: Saturate with N = 32 and a shift of 0 returns `src_a` unchanged, including 32'h80000000.
- R11: Under the custom opcode, a select of 3'b011 to 3'b111 is illegal, and so is a select of 3'b001 or 3'b010 with a nonzero qualifier. An illegal instruction gives `illegal` = 1 and `wr_en` = 0.
- R12: The outputs are registered with one cycle of latency. They reflect the inputs sampled at the previous rising edge, and `in_valid` = 0 gives `wr_en` = 0 and `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| src_d | input | 32 | Current destination register value |
| wr_en | output | 1 | Write the result to the destination register |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Result value |
| illegal | output | 1 | Custom opcode with an unsupported select or qualifier |

## Verification
The unit holds no state beyond its single output register. A decode fault or a datapath fault therefore shows up at the ports on the cycle right after the faulty instruction, as a wrong `wr_en`, a wrong `illegal` or a wrong `wr_data`. The vectors aim at the places where such faults hide without showing. These are the clamp edges at N = 1 and N = 32, shifts that push a negative value to -1, the most negative byte lanes, and wrap-around in both accumulating operations. A wrong gating term would let a write through for destination 0, for an out-of-range N or shift, or for an idle cycle, and the write enable would show this on the next cycle.

// File: rtl/nnx_pkg.sv
package nnx_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned IDX_W    = 5;
    localparam int unsigned QUAL_W   = 7;
    localparam logic [6:0]  OPC_NNX  = 7'b0101011;

    localparam logic [2:0]  SEL_SAT  = 3'b000;
    localparam logic [2:0]  SEL_DOT  = 3'b001;
    localparam logic [2:0]  SEL_MAC  = 3'b010;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SAT,
        OP_DOT,
        OP_MAC,
        OP_BAD
    } nnx_op_e;

    typedef struct packed {
        nnx_op_e             op;
        logic [IDX_W-1:0]    rd;
        logic [QUAL_W-1:0]   qual;
    } nnx_dec_t;

    typedef struct packed {
        logic                we;
        logic                bad;
        logic [IDX_W-1:0]    idx;
        logic [DATA_W-1:0]   data;
    } nnx_res_t;

    function automatic logic [6:0] f_opcode(input logic [31:0] w);
        return w[6:0];
    endfunction

    function automatic logic [2:0] f_sel(input logic [31:0] w);
        return w[14:12];
    endfunction

    function automatic logic [IDX_W-1:0] f_rd(input logic [31:0] w);
        return w[11:7];
    endfunction

    function automatic logic [QUAL_W-1:0] f_qual(input logic [31:0] w);
        return w[31:25];
    endfunction

endpackage

// File: rtl/nnx_decode.sv
module nnx_decode
    import nnx_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    output nnx_dec_t    dec
);
    logic [2:0] sel;
    logic       qual_zero;

    assign sel       = f_sel(instr);
    assign qual_zero = (f_qual(instr) == '0);

    always_comb begin
        dec.rd   = f_rd(instr);
        dec.qual = f_qual(instr);
        dec.op   = OP_NONE;
        if (valid && f_opcode(instr) == OPC_NNX) begin
            unique case (sel)
                SEL_SAT: dec.op = OP_SAT;
                SEL_DOT: dec.op = qual_zero ? OP_DOT : OP_BAD;
                SEL_MAC: dec.op = qual_zero ? OP_MAC : OP_BAD;
                default: dec.op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/nnx_sat.sv
module nnx_sat #(
    parameter int unsigned W      = 32,
    parameter int unsigned NPOS_W = 7
) (
    input  logic [W-1:0]      val,
    input  logic [W-1:0]      shamt,
    input  logic [NPOS_W-1:0] npos,
    output logic              ok,
    output logic [W-1:0]      res
);
    localparam int unsigned SH_W = $clog2(W);

    logic signed [W-1:0] shifted;
    logic signed [W:0]   wide;
    logic signed [W:0]   pw;
    logic signed [W:0]   lim_hi;
    logic signed [W:0]   lim_lo;
    logic signed [W:0]   clamped;
    logic [NPOS_W-1:0]   npos_m1;
    logic                shift_ok;
    logic                npos_ok;

    assign shift_ok = (shamt < W);
    assign npos_ok  = (npos != '0) && (npos <= NPOS_W'(W));
    assign ok       = shift_ok && npos_ok;

    assign shifted  = $signed(val) >>> shamt[SH_W-1:0];
    assign wide     = {shifted[W-1], shifted};
    assign npos_m1  = npos - NPOS_W'(1);
    assign pw       = $signed({{W{1'b0}}, 1'b1} << npos_m1);
    assign lim_hi   = pw - $signed({{W{1'b0}}, 1'b1});
    assign lim_lo   = -pw;

    always_comb begin
        if (wide > lim_hi)      clamped = lim_hi;
        else if (wide < lim_lo) clamped = lim_lo;
        else                    clamped = wide;
    end

    assign res = clamped[W-1:0];
endmodule

// File: rtl/nnx_dot.sv
module nnx_dot #(
    parameter int unsigned W      = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] acc,
    output logic [W-1:0] res
);
    localparam int unsigned LANES  = W / LANE_W;
    localparam int unsigned PROD_W = 2 * LANE_W;
    localparam int unsigned SUM_W  = PROD_W + $clog2(LANES) + 1;

    logic signed [PROD_W-1:0] prod [LANES];
    logic signed [SUM_W-1:0]  sum;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign prod[i] = $signed(a[i*LANE_W +: LANE_W]) * $signed(b[i*LANE_W +: LANE_W]);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

    assign res = acc + {{(W-SUM_W){sum[SUM_W-1]}}, sum};
endmodule

// File: rtl/nnx_mac.sv
module nnx_mac #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] acc,
    output logic [W-1:0] res
);
    logic signed [2*W-1:0] prod;

    assign prod = $signed(a) * $signed(b);
    assign res  = prod[W-1:0] + acc;
endmodule

// File: rtl/nnx_alu.sv
module nnx_alu
    import nnx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [31:0] src_d,
    output logic        wr_en,
    output logic [4:0]  wr_idx,
    output logic [31:0] wr_data,
    output logic        illegal
);
    nnx_dec_t          dec;
    logic              sat_ok;
    logic [DATA_W-1:0] sat_res;
    logic [DATA_W-1:0] dot_res;
    logic [DATA_W-1:0] mac_res;
    nnx_res_t          nxt;
    nnx_res_t          cur;

    nnx_decode u_dec (
        .valid (in_valid),
        .instr (instr),
        .dec   (dec)
    );

    nnx_sat #(.W(DATA_W), .NPOS_W(QUAL_W)) u_sat (
        .val   (src_a),
        .shamt (src_b),
        .npos  (dec.qual),
        .ok    (sat_ok),
        .res   (sat_res)
    );

    nnx_dot #(.W(DATA_W), .LANE_W(8)) u_dot (
        .a   (src_a),
        .b   (src_b),
        .acc (src_d),
        .res (dot_res)
    );

    nnx_mac #(.W(DATA_W)) u_mac (
        .a   (src_a),
        .b   (src_b),
        .acc (src_d),
        .res (mac_res)
    );

    always_comb begin
        nxt.idx  = dec.rd;
        nxt.bad  = 1'b0;
        nxt.we   = 1'b0;
        nxt.data = '0;
        unique case (dec.op)
            OP_SAT: begin
                nxt.we   = sat_ok;
                nxt.data = sat_res;
            end
            OP_DOT: begin
                nxt.we   = 1'b1;
                nxt.data = dot_res;
            end
            OP_MAC: begin
                nxt.we   = 1'b1;
                nxt.data = mac_res;
            end
            OP_BAD:  nxt.bad = 1'b1;
            default: ;
        endcase
        if (dec.rd == '0) nxt.we = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign wr_en   = cur.we;
    assign wr_idx  = cur.idx;
    assign wr_data = cur.data;
    assign illegal = cur.bad;
endmodule

// File: rtl/nnx_alu_chk.sv
module nnx_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [31:0] src_d,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        illegal
);
    logic        was_sat;
    logic [6:0]  npos_q;
    logic        was_ours;
    logic        was_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_sat   <= 1'b0;
            npos_q    <= '0;
            was_ours  <= 1'b0;
            was_valid <= 1'b0;
        end else begin
            was_valid <= in_valid;
            was_ours  <= in_valid && (instr[6:0] == 7'b0101011);
            was_sat   <= in_valid && (instr[6:0] == 7'b0101011) && (instr[14:12] == 3'b000);
            npos_q    <= instr[31:25];
        end
    end

    logic signed [32:0] hi_q;
    logic signed [32:0] lo_q;
    logic signed [32:0] out_w;
    assign hi_q  = (npos_q == 0) ? 33'sd0 : ($signed(33'd1 << (npos_q - 7'd1)) - 33'sd1);
    assign lo_q  = -hi_q - 33'sd1;
    assign out_w = {wr_data[31], wr_data};

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> was_valid); // R12

    AST_NO_WRITE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx != 5'd0)); // R9

    AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en); // R11

    AST_ACT_ONLY_ON_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (wr_en || illegal) |-> was_ours); // R2

    AST_SAT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && was_sat) |-> (out_w <= hi_q && out_w >= lo_q)); // R4
endmodule

bind nnx_alu nnx_alu_chk u_chk (.*);

// File: tb/nnx_alu_bench.sv
module nnx_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] src_d = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        illegal;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    nnx_alu u_nnx_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .src_d(src_d),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [6:0] q, input logic [2:0] s,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {q, 5'd2, 5'd1, s, rd, opc};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] d;
        logic        we;
        logic        ill;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam logic [6:0] OP = 7'b0101011;
    localparam vec_t VT [NV] = '{
        // R4 clamp high, N=8
        '{mk(7'd8, 3'd0, 5'd5, OP), 32'd1000, 32'd0, 32'd0, 1'b1, 1'b0, 32'h0000007F, 8'd4},
        // R4 clamp low after shift by 2
        '{mk(7'd8, 3'd0, 5'd5, OP), 32'hFFFFFC18, 32'd2, 32'd0, 1'b1, 1'b0, 32'hFFFFFF80, 8'd4},
        // R3 shift by 4, in range
        '{mk(7'd16, 3'd0, 5'd6, OP), 32'h00012345, 32'd4, 32'd0, 1'b1, 1'b0, 32'h00001234, 8'd3},
        // R3 arithmetic shift by 31 of negative
        '{mk(7'd8, 3'd0, 5'd7, OP), 32'h80000000, 32'd31, 32'd0, 1'b1, 1'b0, 32'hFFFFFFFF, 8'd3},
        // R10 N=32 identity, most negative
        '{mk(7'd32, 3'd0, 5'd8, OP), 32'h80000000, 32'd0, 32'd0, 1'b1, 1'b0, 32'h80000000, 8'd10},
        // R10 N=32 identity, most positive
        '{mk(7'd32, 3'd0, 5'd8, OP), 32'h7FFFFFFF, 32'd0, 32'd0, 1'b1, 1'b0, 32'h7FFFFFFF, 8'd10},
        // R4 N=1 positive -> 0
        '{mk(7'd1, 3'd0, 5'd9, OP), 32'd5, 32'd0, 32'd0, 1'b1, 1'b0, 32'h00000000, 8'd4},
        // R4 N=1 negative -> -1
        '{mk(7'd1, 3'd0, 5'd9, OP), 32'hFFFFFFF9, 32'd0, 32'd0, 1'b1, 1'b0, 32'hFFFFFFFF, 8'd4},
        // R5 N=0 no write
        '{mk(7'd0, 3'd0, 5'd9, OP), 32'd5, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0, 8'd5},
        // R5 N=33 no write
        '{mk(7'd33, 3'd0, 5'd9, OP), 32'd5, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0, 8'd5},
        // R5 shift 32 no write
        '{mk(7'd8, 3'd0, 5'd9, OP), 32'd5, 32'd32, 32'd0, 1'b0, 1'b0, 32'h0, 8'd5},
        // R5 shift huge (low bits zero would pass) no write
        '{mk(7'd8, 3'd0, 5'd9, OP), 32'd5, 32'h00000100, 32'd0, 1'b0, 1'b0, 32'h0, 8'd5},
        // R9 saturate to x0
        '{mk(7'd8, 3'd0, 5'd0, OP), 32'd5, 32'd0, 32'd0, 1'b0, 1'b0, 32'h0, 8'd9},
        // R6 simple lanes plus accumulator
        '{mk(7'd0, 3'd1, 5'd10, OP), 32'h01020304, 32'h05060708, 32'd10, 1'b1, 1'b0, 32'h00000050, 8'd6},
        // R6 all lanes most negative
        '{mk(7'd0, 3'd1, 5'd11, OP), 32'h80808080, 32'h80808080, 32'd0, 1'b1, 1'b0, 32'h00010000, 8'd6},
        // R6 mixed signs
        '{mk(7'd0, 3'd1, 5'd12, OP), 32'hFF7F80FF, 32'h01807F02, 32'd0, 1'b1, 1'b0, 32'hFFFF80FD, 8'd6},
        // R7 accumulation wraps
        '{mk(7'd0, 3'd1, 5'd13, OP), 32'h01010101, 32'h01010101, 32'h7FFFFFFE, 1'b1, 1'b0, 32'h80000002, 8'd7},
        // R9 dot to x0
        '{mk(7'd0, 3'd1, 5'd0, OP), 32'h01010101, 32'h01010101, 32'd0, 1'b0, 1'b0, 32'h0, 8'd9},
        // R8 negative times positive plus acc
        '{mk(7'd0, 3'd2, 5'd14, OP), 32'hFFFFFFFD, 32'd7, 32'd100, 1'b1, 1'b0, 32'h0000004F, 8'd8},
        // R8 product low word zero
        '{mk(7'd0, 3'd2, 5'd15, OP), 32'h00010000, 32'h00010000, 32'd5, 1'b1, 1'b0, 32'h00000005, 8'd8},
        // R8 overflow wraps
        '{mk(7'd0, 3'd2, 5'd16, OP), 32'h7FFFFFFF, 32'd2, 32'd0, 1'b1, 1'b0, 32'hFFFFFFFE, 8'd8},
        // R9 mac to x0
        '{mk(7'd0, 3'd2, 5'd0, OP), 32'd3, 32'd3, 32'd0, 1'b0, 1'b0, 32'h0, 8'd9},
        // R11 select 3
        '{mk(7'd0, 3'd3, 5'd17, OP), 32'd3, 32'd3, 32'd0, 1'b0, 1'b1, 32'h0, 8'd11},
        // R11 select 7
        '{mk(7'd0, 3'd7, 5'd17, OP), 32'd3, 32'd3, 32'd0, 1'b0, 1'b1, 32'h0, 8'd11},
        // R11 dot with qualifier 1
        '{mk(7'd1, 3'd1, 5'd17, OP), 32'd3, 32'd3, 32'd0, 1'b0, 1'b1, 32'h0, 8'd11},
        // R11 mac with qualifier 0x40
        '{mk(7'h40, 3'd2, 5'd17, OP), 32'd3, 32'd3, 32'd0, 1'b0, 1'b1, 32'h0, 8'd11},
        // R2 other opcode ignored
        '{mk(7'd0, 3'd1, 5'd18, 7'b0110011), 32'd3, 32'd3, 32'd0, 1'b0, 1'b0, 32'h0, 8'd2},
        // R2 other custom opcode, bad select, not flagged
        '{mk(7'd0, 3'd5, 5'd18, 7'b0001011), 32'd3, 32'd3, 32'd0, 1'b0, 1'b0, 32'h0, 8'd2},
        // R12 back-to-back follows each input
        '{mk(7'd0, 3'd1, 5'd19, OP), 32'h00000002, 32'h00000003, 32'd1, 1'b1, 1'b0, 32'h00000007, 8'd12}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] d);
        in_valid = v; instr = ins; src_a = a; src_b = b; src_d = d;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
        check("R1 illegal in reset", {31'd0, illegal}, 32'd0);
        rst = 1'b0;
        drive(1'b1, mk(7'd0, 3'd3, 5'd4, OP), 32'd0, 32'd0, 32'd0);
        @(negedge clk);
        check("R11 illegal after reset release", {31'd0, illegal}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VT[i].ins, VT[i].a, VT[i].b, VT[i].d);
            @(negedge clk);
            check($sformatf("R%0d vec%0d wr_en", VT[i].req, i), {31'd0, wr_en}, {31'd0, VT[i].we});
            check($sformatf("R%0d vec%0d illegal", VT[i].req, i), {31'd0, illegal}, {31'd0, VT[i].ill});
            if (VT[i].we) begin
                check($sformatf("R%0d vec%0d data", VT[i].req, i), wr_data, VT[i].data);
                check($sformatf("R%0d vec%0d idx", VT[i].req, i), {27'd0, wr_idx}, {27'd0, VT[i].ins[11:7]});
            end
        end

        // R12 valid low suppresses a well-formed mac
        drive(1'b0, mk(7'd0, 3'd2, 5'd20, OP), 32'd3, 32'd3, 32'd0);
        @(negedge clk);
        check("R12 idle wr_en", {31'd0, wr_en}, 32'd0);
        check("R12 idle illegal", {31'd0, illegal}, 32'd0);
        drive(1'b0, mk(7'd0, 3'd6, 5'd20, OP), 32'd3, 32'd3, 32'd0);
        @(negedge clk);
        check("R12 idle bad select not flagged", {31'd0, illegal}, 32'd0);

        // R1 reset mid-stream clears a pending write
        drive(1'b1, mk(7'd0, 3'd2, 5'd21, OP), 32'd3, 32'd3, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears wr_en", {31'd0, wr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after reset mac", wr_data, 32'd9);
        check("R8 after reset wr_en", {31'd0, wr_en}, 32'd1);
        drive(1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule